// File: doc/BRIEF.md
# Command List Sequencer

This block stores a host-loaded list of 32-bit command words and, once told to start, plays them back in order onto six command output lines. The host fills the list through a simple write port with an auto-incrementing pointer, which it can rewind to the first entry at any time. A start pulse makes the sequencer fetch words from entry 0 upward.

Each word carries a command code, a six-bit mask of output lines and a 16-bit data field. Real commands appear for one cycle on the lines their mask selects, together with a strobe. A calibration command also holds the sequencer idle for the number of clock cycles in its data field. Other codes are skipped. An end code, or running past the last entry, stops playback and sets a completion flag. The flag stays set until the next start.

The controller has four named states. `S_IDLE` waits for start and takes host writes. `S_FETCH` reads the next entry. `S_ISSUE` decodes the entry and drives the outputs. `S_WAIT` counts down a calibration delay. The transitions are:
- start: `S_IDLE` to `S_FETCH`.
- read: `S_FETCH` to `S_ISSUE`.
- terminate: `S_ISSUE` to `S_IDLE`, on the end code or on the last entry.
- hold: `S_ISSUE` to `S_WAIT`, on a calibration command with a non-zero delay.
- advance: `S_ISSUE` or `S_WAIT` to `S_FETCH`.
- wait-over: `S_WAIT` to `S_IDLE`, when the delay expires on the last entry.

Top module: `cmd_seq_top`

## Requirements
- R1: A host write in `S_IDLE` stores `wr_data` at the write pointer, and the pointer then increments. The pointer wraps from entry 1023 to entry 0. `wr_ptr_clr` sets the pointer to 0 and takes priority over a write in the same cycle.
- R2: A start pulse seen in `S_IDLE` begins playback at entry 0. The first entry is presented two clock edges after the start edge. Each entry that is not a calibration command takes exactly two cycles.
- R3: Word layout: the code sits in bits [31:28], the line mask in [27:22] (bit 22 drives line 0), and the data or delay count in [15:0]. Bits [21:16] are ignored.
- R4: Codes 1, 2, 3 and 5 raise `cmd_strobe` for exactly one cycle. In that cycle `cmd_code` shows the code and `cmd_lines` equals the mask. In every other cycle `cmd_code` and `cmd_lines` are 0.
- R5: Code 5 is a calibration command. After its strobe cycle the sequencer stays silent for exactly as many cycles as its delay count before fetching the next entry. A delay of 0 adds no cycles.
- R6: Code 0 ends playback without a strobe. On the next cycle `busy` is 0 and `done` is 1.
- R7: Any code other than 0, 1, 2, 3 or 5 gives no strobe and takes two cycles, the same as a plain command.
- R8: When no end code is present, playback stops after entry 1023 has been presented and sets `done`.
- R9: `busy` is 1 from the cycle after an accepted start until playback stops. `done` is 0 after reset, is cleared by an accepted start, and once set stays set until the next start.
- R10: Host writes and start pulses that arrive while `busy` is 1 have no effect on the stored list or on playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host command word |
| wr_ptr_clr | input | 1 | Rewind the write pointer to entry 0 |
| start | input | 1 | Begin playback from entry 0 |
| cmd_strobe | output | 1 | A command is being presented this cycle |
| cmd_code | output | 4 | Code of the presented command, else 0 |
| cmd_lines | output | 6 | Per-line command drive, masked by the entry |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Playback finished, held until the next start |

## Verification
Two pairs of events can land in the same cycle: a host write or a new start can coincide with playback, and the end of playback can coincide with a pending start. The bench provokes both by raising `start` and writing zero words during every issue cycle of a run, with the pointer rewound so that any accepted write would overwrite entry 0. It judges the run by comparing each presented entry and its timing against a model of the list. It then replays the same list undisturbed and expects the same result.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_ISSUE = 2'd2,
        S_WAIT  = 2'd3
    } seq_state_t;

    localparam int unsigned OP_END = 0;
    localparam int unsigned OP_A   = 1;
    localparam int unsigned OP_B   = 2;
    localparam int unsigned OP_C   = 3;
    localparam int unsigned OP_CAL = 5;

endpackage

// File: rtl/cmd_seq_buf.sv
module cmd_seq_buf #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;

    // pointer: rewind wins over an increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_clr)
            wr_ptr <= '0;
        else if (wr_en)
            wr_ptr <= wr_ptr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en && !wr_clr)
            mem[wr_ptr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
    import cmd_seq_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int CODE_W = 4,
    parameter int LINES  = 6,
    parameter int DATA_W = 16
) (
    input  logic [WIDTH-1:0]  word,
    output logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  mask,
    output logic [DATA_W-1:0] data,
    output logic              is_cmd,
    output logic              is_end,
    output logic              is_cal
);

    localparam int CODE_LO = WIDTH - CODE_W;
    localparam int MASK_LO = CODE_LO - LINES;

    always_comb begin
        code   = word[WIDTH-1:CODE_LO];
        mask   = word[CODE_LO-1:MASK_LO];
        data   = word[DATA_W-1:0];
        is_end = (code == CODE_W'(OP_END));
        is_cal = (code == CODE_W'(OP_CAL));
        is_cmd = (code == CODE_W'(OP_A)) || (code == CODE_W'(OP_B)) ||
                 (code == CODE_W'(OP_C)) || is_cal;
    end

endmodule

// File: rtl/cmd_seq_delay.sv
module cmd_seq_delay #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              count,
    output logic              expire
);

    logic [DATA_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (count && remain != '0)
            remain <= remain - DATA_W'(1);
    end

    // last waiting cycle is the one holding a count of one
    assign expire = (remain == DATA_W'(1));

endmodule

// File: rtl/cmd_seq_top.sv
module cmd_seq_top
    import cmd_seq_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int WIDTH  = 32,
    parameter int CODE_W = 4,
    parameter int LINES  = 6,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              wr_ptr_clr,
    input  logic              start,
    output logic              cmd_strobe,
    output logic [CODE_W-1:0] cmd_code,
    output logic [LINES-1:0]  cmd_lines,
    output logic              busy,
    output logic              done
);

    seq_state_t        state, state_nx;
    logic [AW-1:0]     rd_addr, addr_nx;
    logic              done_nx;
    logic [WIDTH-1:0]  word;
    logic [CODE_W-1:0] dec_code;
    logic [LINES-1:0]  dec_mask;
    logic [DATA_W-1:0] dec_data;
    logic              dec_cmd, dec_end, dec_cal;
    logic              dly_load, dly_expire;
    logic              host_wr;
    logic              last_entry;

    assign host_wr    = wr_en && (state == S_IDLE);
    assign last_entry = (rd_addr == AW'(DEPTH - 1));

    cmd_seq_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_clr  (wr_ptr_clr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (word)
    );

    cmd_seq_decode #(
        .WIDTH(WIDTH), .CODE_W(CODE_W), .LINES(LINES), .DATA_W(DATA_W)
    ) u_dec (
        .word   (word),
        .code   (dec_code),
        .mask   (dec_mask),
        .data   (dec_data),
        .is_cmd (dec_cmd),
        .is_end (dec_end),
        .is_cal (dec_cal)
    );

    cmd_seq_delay #(.DATA_W(DATA_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dec_data),
        .count    (state == S_WAIT),
        .expire   (dly_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            rd_addr <= '0;
            done    <= 1'b0;
        end else begin
            state   <= state_nx;
            rd_addr <= addr_nx;
            done    <= done_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        addr_nx  = rd_addr;
        done_nx  = done;
        dly_load = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nx = S_FETCH;
                    addr_nx  = '0;
                    done_nx  = 1'b0;
                end
            end
            S_FETCH: begin
                state_nx = S_ISSUE;
            end
            S_ISSUE: begin
                if (dec_end) begin
                    state_nx = S_IDLE;
                    done_nx  = 1'b1;
                end else if (dec_cal && dec_data != '0) begin
                    state_nx = S_WAIT;
                    dly_load = 1'b1;
                end else if (last_entry) begin
                    state_nx = S_IDLE;
                    done_nx  = 1'b1;
                end else begin
                    state_nx = S_FETCH;
                    addr_nx  = rd_addr + AW'(1);
                end
            end
            S_WAIT: begin
                if (dly_expire) begin
                    if (last_entry) begin
                        state_nx = S_IDLE;
                        done_nx  = 1'b1;
                    end else begin
                        state_nx = S_FETCH;
                        addr_nx  = rd_addr + AW'(1);
                    end
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        cmd_strobe = (state == S_ISSUE) && dec_cmd;
        cmd_code   = cmd_strobe ? dec_code : '0;
        cmd_lines  = cmd_strobe ? dec_mask : '0;
    end

endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk #(
    parameter int CODE_W = 4,
    parameter int LINES  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cmd_strobe,
    input logic [CODE_W-1:0] cmd_code,
    input logic [LINES-1:0]  cmd_lines,
    input logic              busy,
    input logic              done
);

    assert_quiet_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |-> (cmd_lines == '0 && cmd_code == '0));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    assert_valid_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (cmd_code == CODE_W'(1) || cmd_code == CODE_W'(2) ||
                        cmd_code == CODE_W'(3) || cmd_code == CODE_W'(5)));

    assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_stop_sets_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind cmd_seq_top cmd_seq_chk #(.CODE_W(CODE_W), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_strobe (cmd_strobe),
    .cmd_code   (cmd_code),
    .cmd_lines  (cmd_lines),
    .busy       (busy),
    .done       (done)
);

// File: tb/tb_cmd_seq_top.sv
module tb_cmd_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ptr_clr = 1'b0;
    logic        start = 1'b0;
    logic        cmd_strobe;
    logic [3:0]  cmd_code;
    logic [5:0]  cmd_lines;
    logic        busy;
    logic        done;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model [DEPTH];
    int          ptr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_seq_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ptr_clr(wr_ptr_clr), .start(start), .cmd_strobe(cmd_strobe),
        .cmd_code(cmd_code), .cmd_lines(cmd_lines), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_cmd(input logic [3:0] c);
        return c == 4'd1 || c == 4'd2 || c == 4'd3 || c == 4'd5;
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [5:0] m,
                                       input logic [15:0] d);
        return {c, m, 6'($urandom), d};
    endfunction

    // called at a negedge; returns at a later negedge
    task automatic put(input logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        model[ptr] = w;
        ptr = (ptr + 1) % DEPTH;
    endtask

    task automatic rewind();
        wr_ptr_clr = 1'b1;
        @(negedge clk);
        wr_ptr_clr = 1'b0;
        ptr = 0;
    endtask

    task automatic run_list(input bit noise);
        int a;
        bit fin;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R9", "busy set, done cleared by start", {busy, done}, 2'b10);
        @(negedge clk);
        a = 0;
        fin = 1'b0;
        while (!fin) begin
            logic [31:0] w;
            logic [3:0]  c;
            bit          s;
            int          extra;
            bit          quiet;
            string       tag;
            w = model[a];
            c = w[31:28];
            s = is_cmd(c);
            tag = (c == 4'd5) ? "R5 R3" : (c == 4'd0) ? "R6" : s ? "R4 R3" : "R7";
            chk(busy && cmd_strobe == s && cmd_code == (s ? c : 4'd0) &&
                cmd_lines == (s ? w[27:22] : 6'd0), tag, $sformatf("entry %0d", a),
                {busy, cmd_strobe, cmd_code, cmd_lines},
                {1'b1, s, s ? c : 4'd0, s ? w[27:22] : 6'd0});
            if (noise) begin
                start = 1'b1; wr_en = 1'b1; wr_data = '0;
            end
            if (c == 4'd0) begin
                @(negedge clk);
                start = 1'b0; wr_en = 1'b0;
                chk(done && !busy, "R6", "stop on end code", {done, busy}, 2'b10);
                fin = 1'b1;
            end else begin
                extra = (c == 4'd5) ? int'(w[15:0]) : 0;
                quiet = 1'b1;
                for (int k = 0; k < extra; k++) begin
                    @(negedge clk);
                    start = 1'b0; wr_en = 1'b0;
                    if (cmd_strobe || !busy) quiet = 1'b0;
                end
                if (a == DEPTH - 1) begin
                    @(negedge clk);
                    start = 1'b0; wr_en = 1'b0;
                    chk(done && !busy, "R8", "stop after last entry", {done, busy}, 2'b10);
                    fin = 1'b1;
                end else begin
                    @(negedge clk);
                    start = 1'b0; wr_en = 1'b0;
                    if (cmd_strobe || !busy) quiet = 1'b0;
                    @(negedge clk);
                    a++;
                end
                if (extra > 0)
                    chk(quiet, "R5", "silent delay window", quiet, 1);
            end
        end
    endtask

    task automatic rand_list(input int n);
        rewind();
        for (int i = 0; i < n; i++) begin
            int r;
            logic [3:0] c;
            r = int'($urandom % 10);
            c = (r < 6) ? 4'(1 + r % 3) : (r < 8) ? 4'd5 : 4'(6 + $urandom % 10);
            if (c == 4'd4) c = 4'd5;
            put(mk(c, 6'($urandom), (c == 4'd5) ? 16'($urandom % 7) : 16'($urandom)));
        end
        put(mk(4'd0, 6'($urandom), 16'($urandom)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d3a7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !cmd_strobe && cmd_lines == 0 && cmd_code == 0,
            "R9", "reset state", {busy, done, cmd_strobe, cmd_code, cmd_lines}, 0);

        // directed list: every code class, zero and non-zero delays (R3 layout)
        put(mk(4'd1, 6'h3f, 16'h1234));
        put(mk(4'd2, 6'h01, 16'h0000));
        put(mk(4'd3, 6'h20, 16'hffff));
        put(mk(4'd5, 6'h15, 16'd4));
        put(mk(4'd4, 6'h3f, 16'd9));
        put(mk(4'd15, 6'h2a, 16'd3));
        put(mk(4'd5, 6'h0c, 16'd0));
        put(mk(4'd5, 6'h00, 16'd7));
        put(mk(4'd0, 6'h3f, 16'd5));
        run_list(1'b0);

        // R9: done holds while idle
        repeat (6) @(negedge clk);
        chk(done && !busy, "R9", "done held while idle", {done, busy}, 2'b10);

        // R1: rewind then overwrite entry 0 only; rest of list is kept
        rewind();
        put(mk(4'd2, 6'h2d, 16'd0));
        run_list(1'b0);

        // R10: writes and starts during playback are ignored; replay must match
        rewind();
        run_list(1'b1);
        run_list(1'b0);

        // R1: rewind has priority over a same-cycle write
        wr_ptr_clr = 1'b1; wr_en = 1'b1; wr_data = 32'h0;
        @(negedge clk);
        wr_ptr_clr = 1'b0; wr_en = 1'b0;
        ptr = 0;
        run_list(1'b0);

        // random lists
        for (int t = 0; t < 8; t++) begin
            rand_list(5 + int'($urandom % 30));
            run_list(t[0]);
        end

        // R8: no end code in a full buffer; then R1 pointer wrap to entry 0
        rewind();
        for (int i = 0; i < DEPTH; i++)
            put(mk(4'(1 + $urandom % 3), 6'($urandom), 16'($urandom)));
        run_list(1'b0);
        put(mk(4'd0, 6'h3f, 16'd0));
        run_list(1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule